// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number by reading a two-level page table held in memory. A requester presents a virtual address. The walker splits it into a 10-bit top-level index, a 10-bit second-level index and a 12-bit page offset. It reads the top-level entry found at the root table base, and if that entry is marked present it reads the entry in the second-level table that the top-level entry points to. Each second-level table covers 4 MB of virtual space.

The walk finishes with a one-cycle result that carries either the frame number or a fault together with the level at which the walk stopped. When a top-level entry is not present, the walk stops after one memory read and never issues the second. Only one walk runs at a time. A new address is taken only when the walker is idle.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `mem_req_valid` are 0.
- R2: The first read after a request is taken goes to `{root_base[31:12], 12'b0} + 4*vaddr[31:22]`. Bits 11:0 of `root_base` have no effect.
- R3: A table entry is present when bit 0 is 1. If the top-level entry is not present, the result is `fault`=1 with `fault_level`=0, and exactly one memory read was issued for that walk.
- R4: The second read goes to `{top_entry[31:12], 12'b0} + 4*vaddr[21:12]`.
- R5: If the second-level entry is not present, the result is `fault`=1 with `fault_level`=1, after exactly two reads.
- R6: If the second-level entry is present, the result is `fault`=0, `fault_level`=0 and `frame` = `leaf_entry[31:12]`. Entry bits 11:1 have no effect.
- R7: `done` is high for exactly one cycle per walk. Outside that cycle, `frame`, `fault` and `fault_level` are 0.
- R8: `req_ready` is high only while idle. A `req_valid` held high through a whole walk starts no second walk until `req_ready` has been seen high again.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` stays stable in the next cycle.
- R10: A `mem_rsp_valid` pulse that arrives while no read is outstanding has no effect: no `done`, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Physical base of the top-level table, sampled when a request is taken |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended on a non-present entry |
| fault_level | output | 1 | 0 = top level, 1 = second level |
| frame | output | 20 | Translated frame number |

## Verification
Two events can fall in the same cycle. The first is the done pulse coinciding with a requester that keeps `req_valid` asserted. The second is the memory granting a read in the same cycle the walker first raises it, with the data returned one cycle later. Directed runs use an always-ready memory with the minimum response latency and hold the request high across the whole walk. The run is judged by counting reads and done pulses after the strobe, which must show that no second walk started. Randomized walks vary the memory grant and response latency, and the results and read addresses are compared against a model of the table contents computed in the bench.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TOP,
        ST_WT_TOP,
        ST_RD_LEAF,
        ST_WT_LEAF,
        ST_DONE
    } walk_state_e;

    localparam int unsigned NUM_LEVELS = 2;
    localparam logic        LVL_TOP    = 1'b0;
    localparam logic        LVL_LEAF   = 1'b1;

endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned IDX_W = 10
) (
    input  logic [PA_W-OFF_W-1:0] table_base,
    input  logic [IDX_W-1:0]      index,
    output logic [PA_W-1:0]       entry_addr
);
    localparam int unsigned ENTRY_SHIFT = 2;

    logic [PA_W-1:0] base_bytes;
    logic [PA_W-1:0] index_bytes;

    always_comb begin
        base_bytes  = {table_base, {OFF_W{1'b0}}};
        index_bytes = PA_W'(index) << ENTRY_SHIFT;
        entry_addr  = base_bytes + index_bytes;
    end

endmodule

// File: rtl/pgw_entry_chk.sv
module pgw_entry_chk #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PA_W-1:0]       entry,
    output logic                  present,
    output logic [PA_W-OFF_W-1:0] next_base
);
    logic unused_attr_bits;

    always_comb begin
        present          = entry[0];
        next_base        = entry[PA_W-1:OFF_W];
        unused_attr_bits = ^entry[OFF_W-1:1];
    end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PA_W-1:0]       root_base,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  req_ready,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PA_W-1:0]       mem_rsp_data,
    output logic                  done,
    output logic                  fault,
    output logic                  fault_level,
    output logic [PA_W-OFF_W-1:0] frame
);
    localparam int unsigned VPN_W   = VA_W - OFF_W;
    localparam int unsigned IDX_W   = VPN_W / 2;
    localparam int unsigned FRAME_W = PA_W - OFF_W;

    typedef struct packed {
        walk_state_e        st;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] root;
        logic [FRAME_W-1:0] leaf_base;
        logic [FRAME_W-1:0] frame;
        logic               fault;
        logic               lvl;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [FRAME_W-1:0] lvl_base [NUM_LEVELS];
    logic [IDX_W-1:0]   lvl_idx  [NUM_LEVELS];
    logic [PA_W-1:0]    lvl_addr [NUM_LEVELS];

    logic               ent_present;
    logic [FRAME_W-1:0] ent_base;
    logic               unused_low_bits;

    assign unused_low_bits = ^{req_vaddr[OFF_W-1:0], root_base[OFF_W-1:0]};

    assign lvl_base[0] = r_q.root;
    assign lvl_base[1] = r_q.leaf_base;
    assign lvl_idx[0]  = r_q.vpn[VPN_W-1 -: IDX_W];
    assign lvl_idx[1]  = r_q.vpn[IDX_W-1:0];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        pgw_entry_addr #(
            .PA_W  (PA_W),
            .OFF_W (OFF_W),
            .IDX_W (IDX_W)
        ) u_addr (
            .table_base (lvl_base[g]),
            .index      (lvl_idx[g]),
            .entry_addr (lvl_addr[g])
        );
    end

    pgw_entry_chk #(
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) u_chk (
        .entry     (mem_rsp_data),
        .present   (ent_present),
        .next_base (ent_base)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vpn  = req_vaddr[VA_W-1:OFF_W];
                    r_d.root = root_base[PA_W-1:OFF_W];
                    r_d.st   = ST_RD_TOP;
                end
            end
            ST_RD_TOP: begin
                if (mem_req_ready) r_d.st = ST_WT_TOP;
            end
            ST_WT_TOP: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        r_d.fault = 1'b1;
                        r_d.lvl   = LVL_TOP;
                        r_d.frame = '0;
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.leaf_base = ent_base;
                        r_d.st        = ST_RD_LEAF;
                    end
                end
            end
            ST_RD_LEAF: begin
                if (mem_req_ready) r_d.st = ST_WT_LEAF;
            end
            ST_WT_LEAF: begin
                if (mem_rsp_valid) begin
                    r_d.st = ST_DONE;
                    if (!ent_present) begin
                        r_d.fault = 1'b1;
                        r_d.lvl   = LVL_LEAF;
                        r_d.frame = '0;
                    end else begin
                        r_d.fault = 1'b0;
                        r_d.lvl   = LVL_TOP;
                        r_d.frame = ent_base;
                    end
                end
            end
            ST_DONE: begin
                r_d.fault = 1'b0;
                r_d.lvl   = 1'b0;
                r_d.frame = '0;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_RD_TOP) || (r_q.st == ST_RD_LEAF);
    assign mem_req_addr  = (r_q.st == ST_RD_LEAF) ? lvl_addr[1] : lvl_addr[0];
    assign done          = (r_q.st == ST_DONE);
    assign fault         = r_q.fault;
    assign fault_level   = r_q.lvl;
    assign frame         = r_q.frame;

    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (frame == '0) && !fault && !fault_level); // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !done); // R8
    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && !req_valid |=> req_ready); // R10

endmodule

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done, fault, fault_level;
    logic [19:0] frame;

    int n_checks = 0;
    int n_fail   = 0;

    int          rd_count = 0;
    logic [31:0] rd_log [4];
    bit          fast_mem = 1'b0;
    bit          stray_pending = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_walker u_pgw_walker (
        .clk, .rst_n, .root_base, .req_valid, .req_vaddr, .req_ready,
        .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_data,
        .done, .fault, .fault_level, .frame
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EB_CA6B;
        h = h ^ (h >> 13);
        return {h[31:1], (h[3:2] != 2'b00)};
    endfunction

    function automatic logic [31:0] top_addr(input logic [31:0] rb, input logic [31:0] va);
        return {rb[31:12], 12'b0} + {20'b0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_addr(input logic [31:0] rb, input logic [31:0] va);
        logic [31:0] e1;
        e1 = mem_word(top_addr(rb, va));
        return {e1[31:12], 12'b0} + {20'b0, va[21:12], 2'b00};
    endfunction

    // Memory model: grant and response latency vary unless fast_mem is set.
    initial begin
        int          lat_cnt;
        logic [31:0] pend;
        bit          stall_prev;
        logic [31:0] stall_addr;
        lat_cnt = 0; pend = '0; stall_prev = 1'b0; stall_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (stall_prev)
                chk(mem_req_valid && (mem_req_addr == stall_addr), "R9 held read",
                    mem_req_addr, stall_addr);
            if (stray_pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_F001;
                stray_pending = 1'b0;
            end else if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend;
                end
            end
            mem_req_ready = fast_mem ? 1'b1 : (($urandom % 3) != 0);
            stall_prev = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (rd_count < 4) rd_log[rd_count] = mem_req_addr;
                rd_count++;
                pend    = mem_word(mem_req_addr);
                lat_cnt = fast_mem ? 1 : 1 + int'($urandom % 3);
            end
        end
    end

    task automatic walk(input logic [31:0] rb, input logic [31:0] va, input bit hold);
        logic [31:0] a1, a2, e1, e2;
        int          cyc;
        bit          busy_ok;
        a1 = top_addr(rb, va);
        e1 = mem_word(a1);
        a2 = leaf_addr(rb, va);
        e2 = mem_word(a2);
        rd_count  = 0;
        root_base = rb;
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        if (!hold) begin
            req_valid = 1'b0;
            req_vaddr = $urandom;
            root_base = $urandom;
        end
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 60) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done, "R7 done seen", 32'(done), 32'd1);
        chk(busy_ok && !req_ready, "R8 ready low while busy", 32'(req_ready), 32'd0);
        chk(rd_log[0] == a1, "R2 top address", rd_log[0], a1);
        if (!e1[0]) begin
            chk(fault && !fault_level, "R3 top fault", {30'b0, fault, fault_level}, 32'h2);
            chk(rd_count == 1, "R3 single read", 32'(rd_count), 32'd1);
        end else begin
            chk(rd_log[1] == a2, "R4 leaf address", rd_log[1], a2);
            if (!e2[0]) begin
                chk(fault && fault_level, "R5 leaf fault", {30'b0, fault, fault_level}, 32'h3);
                chk(rd_count == 2, "R5 two reads", 32'(rd_count), 32'd2);
            end else begin
                chk(!fault && !fault_level && frame == e2[31:12], "R6 frame",
                    {12'b0, frame}, {12'b0, e2[31:12]});
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!done && frame == 0 && !fault && !fault_level, "R7 pulse ends",
            {12'b0, frame}, 32'd0);
        if (hold) begin
            repeat (3) @(negedge clk);
            chk(rd_count <= 2 && req_ready && !done, "R8 no second walk",
                32'(rd_count), 32'd2);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] va, rb;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 reset state",
            {29'b0, req_ready, done, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: stray response while idle
        stray_pending = 1'b1;
        @(negedge clk);
        repeat (2) begin
            @(negedge clk);
            chk(req_ready && !done, "R10 stray response", {30'b0, req_ready, done}, 32'h2);
        end

        // Directed: extreme addresses, root with low bits set, fast memory, held request
        fast_mem = 1'b1;
        walk(32'h0004_0FFF, 32'hFFFF_FFFF, 1'b1);
        walk(32'h0000_0000, 32'h0000_0000, 1'b1);
        // top-level not present
        rb = 32'h1234_5000;
        for (int i = 0; i < 200; i++) begin
            va = $urandom;
            if (!mem_word(top_addr(rb, va))[0]) break;
        end
        walk(rb | 32'h0000_0ABC, va, 1'b1);
        // second-level not present
        for (int i = 0; i < 500; i++) begin
            va = $urandom;
            if (mem_word(top_addr(rb, va))[0] && !mem_word(leaf_addr(rb, va))[0]) break;
        end
        walk(rb, va, 1'b0);
        fast_mem = 1'b0;

        // Random walks with random grant and latency
        for (int i = 0; i < 300; i++) begin
            walk($urandom, $urandom, ($urandom % 4) == 0);
        end
        finish_up();
    end

endmodule